// File: doc/BRIEF.md
# Per-pin GPIO interrupt detector

This block turns the synchronized levels of a GPIO port into per-pin pending flags and two summary requests. Each pin picks level or edge sensitivity and an active polarity. In edge mode a dual-edge bit makes the pin trigger on both transitions, whatever its polarity bit says. A pending flag stays set until software clears it through a write-one-to-clear strobe. The pending word is presented as a read-only status vector.

The block drives two registered outputs. The interrupt request is the OR of every pending flag whose interrupt enable is set. The wake request is the OR of every pending flag whose wake enable is set. The enables affect only these two outputs. Flags are recorded whatever the enables hold.

All pins are plain control and status signals: the block has no streaming data path, so no pin uses a valid/ready handshake. The clear strobe is sampled on every clock and acts on each clock in which it is held.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and on the first clock after it, the pending word, the interrupt request and the wake request are all 0.
- R2: A pin with mode bit 0 (level) and polarity bit 1 sets its flag on the clock edge that samples a high level. With polarity bit 0 it sets the flag on the clock edge that samples a low level. Once set, the flag holds until it is cleared.
- R3: A pin with mode bit 1 (edge) and dual-edge bit 0 sets its flag only where the current sample differs from the previous one. With polarity 1 only a 0-to-1 change sets the flag, and with polarity 0 only a 1-to-0 change sets it. A steady input never sets the flag.
- R4: A pin with mode bit 1 and dual-edge bit 1 sets its flag on both a 0-to-1 and a 1-to-0 change, for either polarity value.
- R5: In level mode the dual-edge bit has no effect. The pin follows only its polarity bit.
- R6: A 1 in bit i of the clear strobe clears pending bit i at that clock edge. Bits where the strobe is 0 keep their value.
- R7: In level mode, a clear forces the flag to 0 for one cycle. If the active level is still present, the flag is set again on the following clock edge.
- R8: In edge mode, if a qualifying edge and a clear reach the same bit on the same clock, the flag ends up set.
- R9: The interrupt request is a register. After each clock edge it equals the OR, across pins, of the pending bit AND the interrupt enable sampled at that edge.
- R10: The wake request is a register. After each clock edge it equals the OR of the pending bit AND the wake enable sampled at that edge, and the interrupt enable does not affect it.
- R11: No edge is reported on the first clock after reset, even when a pin is already at its active edge's final level during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl | input | NPINS | Synchronized pin levels |
| cfg_edge | input | NPINS | Mode per pin: 0 level, 1 edge |
| cfg_pol | input | NPINS | Polarity per pin: 0 low/falling, 1 high/rising |
| cfg_dual | input | NPINS | Dual-edge select per pin (edge mode only) |
| irq_en | input | NPINS | Interrupt enable per pin |
| wake_en | input | NPINS | Wake enable per pin |
| clr_stb | input | NPINS | Write-one-to-clear strobe for the pending flags |
| pend | output | NPINS | Pending status word, 1 = pending |
| irq | output | 1 | Registered interrupt request |
| wake | output | 1 | Registered wake request |

## Verification
The bench builds the block with NPINS set to 8. With eight pins, one test step can hold edge pins, level pins and dual-edge pins side by side, and the hand-worked status words stay short. Every corner is then reachable in a few cycles: a clear landing on a new edge, a level pin asserting again after a clear, and a pin that sits at its active level during reset. A long stretch of random pins, clears and configurations then checks the pending word and both requests against the behavioural model on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } trig_pol_e;

endpackage

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic primed,
  input  logic lvl,
  input  logic mode,
  input  logic pol,
  input  logic dual,
  input  logic clr,
  output logic pend_d,
  output logic pend_q
);

  trig_mode_e mode_e;
  trig_pol_e  pol_e;
  logic       lvl_prev;
  logic       rise, fall, edge_hit, lvl_hit;

  assign mode_e = trig_mode_e'(mode);
  assign pol_e  = trig_pol_e'(pol);

  // Edge detection compares the current sample with the previous one.
  // It stays quiet until one sample has been taken after reset.
  assign rise = primed &  lvl & ~lvl_prev;
  assign fall = primed & ~lvl &  lvl_prev;

  always_comb begin
    if (dual)                  edge_hit = rise | fall;
    else if (pol_e == POL_HIGH) edge_hit = rise;
    else                       edge_hit = fall;
  end

  assign lvl_hit = (pol_e == POL_HIGH) ? lvl : ~lvl;

  always_comb begin
    if (mode_e == TRIG_EDGE) begin
      // A new edge takes priority over a clear on the same clock.
      pend_d = edge_hit | (pend_q & ~clr);
    end else begin
      // A clear drops the flag for one cycle. It sets again if the level is still active.
      pend_d = clr ? 1'b0 : (pend_q | lvl_hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      lvl_prev <= lvl;
      pend_q   <= pend_d;
    end
  end

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] flags,
  input  logic [NPINS-1:0] mask,
  output logic             req_q
);

  logic [NPINS-1:0] qualified;

  assign qualified = flags & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= |qualified;
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic [NPINS-1:0] cfg_edge,
  input  logic [NPINS-1:0] cfg_pol,
  input  logic [NPINS-1:0] cfg_dual,
  input  logic [NPINS-1:0] irq_en,
  input  logic [NPINS-1:0] wake_en,
  input  logic [NPINS-1:0] clr_stb,
  output logic [NPINS-1:0] pend,
  output logic             irq,
  output logic             wake
);

  logic             primed_q;
  logic [NPINS-1:0] pend_next;
  logic [NPINS-1:0] pend_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_irq_pin_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .primed (primed_q),
      .lvl    (pin_lvl[g]),
      .mode   (cfg_edge[g]),
      .pol    (cfg_pol[g]),
      .dual   (cfg_dual[g]),
      .clr    (clr_stb[g]),
      .pend_d (pend_next[g]),
      .pend_q (pend_cur[g])
    );
  end

  // Both requests register the next pending word, so they line up with pend.
  gpio_irq_reduce #(.NPINS(NPINS)) u_irq_or (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (pend_next),
    .mask  (irq_en),
    .req_q (irq)
  );

  gpio_irq_reduce #(.NPINS(NPINS)) u_wake_or (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (pend_next),
    .mask  (wake_en),
    .req_q (wake)
  );

  assign pend = pend_cur;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_lvl,
  input logic [NPINS-1:0] cfg_edge,
  input logic [NPINS-1:0] cfg_pol,
  input logic [NPINS-1:0] cfg_dual,
  input logic [NPINS-1:0] irq_en,
  input logic [NPINS-1:0] wake_en,
  input logic [NPINS-1:0] clr_stb,
  input logic [NPINS-1:0] pend,
  input logic             irq,
  input logic             wake
);

  logic [1:0] settle_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              settle_q <= 2'd0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end
  assign armed = (settle_q == 2'd3);

  // R6: pending bits that are not cleared stay set
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((pend & $past(pend & ~clr_stb)) == $past(pend & ~clr_stb)));

  // R9: interrupt request follows pending AND enable
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (irq == |(pend & $past(irq_en))));

  // R10: wake request follows pending AND wake enable
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (wake == |(pend & $past(wake_en))));

  // R2: an active level on a level pin without a clear always sets the flag
  p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (($past(~cfg_edge & ~clr_stb & ~(pin_lvl ^ cfg_pol)) & ~pend) == '0));

  // R3: a steady input on an edge pin that is not pending leaves it clear
  p_quiet_edge_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    1 |=> ((pend & $past(cfg_edge & ~pend) & ~($past(pin_lvl) ^ $past(pin_lvl, 2))) == '0));

  // R4: any change on a dual-edge pin sets the flag
  p_dual_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    1 |=> (($past(cfg_edge & cfg_dual & (pin_lvl ^ $past(pin_lvl))) & ~pend) == '0));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_lvl  (pin_lvl),
  .cfg_edge (cfg_edge),
  .cfg_pol  (cfg_pol),
  .cfg_dual (cfg_dual),
  .irq_en   (irq_en),
  .wake_en  (wake_en),
  .clr_stb  (clr_stb),
  .pend     (pend),
  .irq      (irq),
  .wake     (wake)
);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_lvl = '0;
  logic [N-1:0] cfg_edge = '0;
  logic [N-1:0] cfg_pol = '0;
  logic [N-1:0] cfg_dual = '0;
  logic [N-1:0] irq_en = '0;
  logic [N-1:0] wake_en = '0;
  logic [N-1:0] clr_stb = '0;
  logic [N-1:0] pend;
  logic         irq, wake;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NPINS(N)) i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_edge(cfg_edge),
    .cfg_pol(cfg_pol), .cfg_dual(cfg_dual), .irq_en(irq_en), .wake_en(wake_en),
    .clr_stb(clr_stb), .pend(pend), .irq(irq), .wake(wake)
  );

  // Behavioural reference model, one pin at a time
  bit [N-1:0] m_pend;
  bit [N-1:0] m_prev;
  bit         m_primed;
  bit         m_irq, m_wake;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_prev = '0; m_primed = 0; m_irq = 0; m_wake = 0;
    end else begin
      bit [N-1:0] nxt;
      for (int i = 0; i < N; i++) begin
        bit now, was, went_up, went_down, fire;
        now = pin_lvl[i];
        was = m_prev[i];
        went_up   = m_primed && now && !was;
        went_down = m_primed && !now && was;
        if (cfg_edge[i]) begin
          if (cfg_dual[i]) fire = went_up || went_down;
          else             fire = cfg_pol[i] ? went_up : went_down;
          nxt[i] = fire || (m_pend[i] && !clr_stb[i]);
        end else begin
          fire = (now == cfg_pol[i]);
          if (clr_stb[i]) nxt[i] = 0;
          else            nxt[i] = m_pend[i] || fire;
        end
      end
      m_irq  = 0;
      m_wake = 0;
      for (int i = 0; i < N; i++) begin
        if (nxt[i] && irq_en[i])  m_irq  = 1;
        if (nxt[i] && wake_en[i]) m_wake = 1;
      end
      m_pend   = nxt;
      m_prev   = pin_lvl;
      m_primed = 1;
    end
  end

  task automatic check_vec(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check_vec({cur_tag, " pend"}, 32'(pend), 32'(m_pend));
      check_vec({cur_tag, " irq"},  32'(irq),  32'(m_irq));
      check_vec({cur_tag, " wake"}, 32'(wake), 32'(m_wake));
    end
  end

  task automatic step(input logic [N-1:0] p, input logic [N-1:0] c);
    pin_lvl = p;
    clr_stb = c;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // Pins 0-3: rising edge. Pins 4-7: low level. Every pin is high during reset.
    cfg_edge = 8'h0F; cfg_pol = 8'h0F; pin_lvl = 8'hFF;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check_vec("R1 pend in reset", 32'(pend), 0);
    check_vec("R1 irq in reset", 32'(irq), 0);
    check_vec("R1 wake in reset", 32'(wake), 0);
    rst_n = 1'b1;
    step(8'hFF, 8'h00);
    check_vec("R1 pend after reset", 32'(pend), 0);
    cur_tag = "R11";
    step(8'hFF, 8'h00);
    check_vec("R11 no edge from reset level", 32'(pend), 0);

    cur_tag = "R3";
    step(8'h00, 8'h00);
    check_vec("R3 falling ignored, R2 low level set", 32'(pend), 32'hF0);
    step(8'h0F, 8'h00);
    check_vec("R3 rising sets", 32'(pend), 32'hFF);

    cur_tag = "R9";
    irq_en = 8'h01; wake_en = 8'h80;
    step(8'h0F, 8'h00);
    check_vec("R9 irq with enable", 32'(irq), 1);
    check_vec("R10 wake with enable", 32'(wake), 1);
    irq_en = 8'h00; wake_en = 8'h00;
    step(8'h0F, 8'h00);
    check_vec("R9 irq masked", 32'(irq), 0);
    check_vec("R10 wake masked", 32'(wake), 0);
    check_vec("R9 flags kept while masked", 32'(pend), 32'hFF);
    irq_en = 8'h00; wake_en = 8'hF0;
    step(8'h0F, 8'h00);
    check_vec("R10 wake independent of irq_en", 32'(wake), 1);
    check_vec("R9 irq off with wake on", 32'(irq), 0);
    wake_en = 8'h00;

    cur_tag = "R6";
    step(8'h0F, 8'h0F);
    check_vec("R6 partial clear", 32'(pend), 32'hF0);
    cur_tag = "R7";
    step(8'h0F, 8'hF0);
    check_vec("R7 level cleared for one cycle", 32'(pend), 32'h00);
    step(8'h0F, 8'h00);
    check_vec("R7 level reasserts", 32'(pend), 32'hF0);

    cur_tag = "R4";
    cfg_pol = 8'h00; cfg_dual = 8'h0C;
    step(8'h0B, 8'h00);
    check_vec("R4 dual falling", 32'(pend), 32'hF4);
    step(8'h0B, 8'h04);
    check_vec("R6 clear single bit", 32'(pend), 32'hF0);
    step(8'h0F, 8'h00);
    check_vec("R4 dual rising with polarity 0", 32'(pend), 32'hF4);
    cur_tag = "R3";
    step(8'h0E, 8'h00);
    check_vec("R3 falling mode sets", 32'(pend), 32'hF5);
    cur_tag = "R8";
    step(8'h0A, 8'h05);
    check_vec("R8 edge beats clear", 32'(pend), 32'hF4);

    cur_tag = "R5";
    cfg_pol = 8'hF0; cfg_dual = 8'hFC;
    step(8'h0A, 8'hF0);
    step(8'h0A, 8'h00);
    check_vec("R5 dual ignored in level mode", 32'(pend), 32'h04);
    cur_tag = "R2";
    step(8'hFA, 8'h00);
    check_vec("R2 high level sets", 32'(pend), 32'hF4);

    cur_tag = "R2 R3 R4 R6 R8 R9 R10 random";
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r1, r2, r3;
      if (k % 64 == 0) begin
        r1 = $urandom; r2 = $urandom; r3 = $urandom;
        cfg_edge = r1[N-1:0]; cfg_pol = r1[N+7:8]; cfg_dual = r1[N+15:16];
        irq_en = r2[N-1:0]; wake_en = r2[N+7:8];
      end
      r1 = $urandom; r2 = $urandom; r3 = $urandom;
      step(r1[N-1:0], r2[N-1:0] & r3[N-1:0]);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule